// File: doc/BRIEF.md
# Streaming Vector Sum Reducer

The block adds up a vector of integers that arrives as a stream, one element per clock, using a single adder with four pipeline stages. Each element carries a valid flag and a flag that marks the final element. While a vector streams in, the adder output is fed back into its second operand. Four independent running sums therefore circulate through the four stages, and each one collects every fourth element. When the final element has been taken in, the control logic merges the four running sums in pairs. A holding register keeps one value while its partner is still passing through the adder. Zero is fed into any operand that has no data.

The block accepts a new vector once the merge has finished. The merge takes twelve cycles in all, so the result always appears the same number of cycles after the last element, whatever the vector length. A ready output is low during that window and input offered then is ignored. The result is presented for one cycle together with a done strobe. All arithmetic wraps modulo 2^WIDTH.

Top module: `vec_reducer`

## Requirements
- R1: After reset is released, `inReady` is 1 and `sumDone` is 0.
- R2: For a vector of N >= 4 elements, `sumOut` equals the sum of all accepted elements in the cycle where `sumDone` is 1.
- R3: An element is accepted in every cycle where both `inValid` and `inReady` are 1, one element per cycle, and `inReady` stays 1 while a vector streams in.
- R4: Cycles with `inValid` at 0 inside a vector (including before its first element) add nothing to the sum, whatever `inData` holds.
- R5: `sumDone` is 1 for exactly one cycle, 12 cycles after the cycle that accepted the element with `inLast` at 1, for every vector length.
- R6: Vectors of 1, 2 and 3 elements give the correct sum, with the same timing as in R5.
- R7: `inReady` is 0 from the cycle after the last element is accepted through the cycle where `sumDone` is 1, and `inValid`, `inLast` and `inData` have no effect during that window.
- R8: The sum wraps modulo 2^WIDTH.
- R9: `inReady` returns to 1 in the cycle after `sumDone`, and a vector that starts then gives its own sum with nothing carried over from the previous one.
- R10: `sumDone` stays 0 when no vector has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Element present on `inData` |
| inLast | input | 1 | Element is the final one of the vector |
| inData | input | WIDTH | Vector element |
| inReady | output | 1 | Block can accept an element this cycle |
| sumOut | output | WIDTH | Reduced sum, meaningful when `sumDone` is 1 |
| sumDone | output | 1 | One-cycle strobe marking the final sum |

## Verification
The only result is due in the twelfth cycle after the clock edge that accepts the final element. `inReady` is due low in the first cycle after that edge and high again in the thirteenth. After the last element, the bench samples at the falling edge of each of the next twelve cycles. It expects `sumDone` only in the twelfth and `inReady` low in all twelve, and it compares `sumOut` with a sum it computes itself in that twelfth cycle. Junk is offered during the window, and the following vector starts at once in the next cycle, so any leak into state would show up in the next result.

// File: rtl/vec_reducer_pkg.sv
package vec_reducer_pkg;
  // Depth of the adder pipeline; the merge schedule below is laid out for 4.
  localparam int ADD_DEPTH = 4;

  // Cycles after the last accepted element (count starts at 1).
  localparam int PARK_A  = 1;
  localparam int MERGE_A = 2;
  localparam int PARK_B  = 3;
  localparam int MERGE_B = 4;
  localparam int PARK_C  = MERGE_A + ADD_DEPTH;
  localparam int MERGE_C = MERGE_B + ADD_DEPTH;
  localparam int FINAL_CYC = MERGE_C + ADD_DEPTH;
  localparam int CNT_W = $clog2(FINAL_CYC + 1);

  typedef enum logic [1:0] {
    OPA_ZERO   = 2'd0,
    OPA_STREAM = 2'd1,
    OPA_PARK   = 2'd2
  } opaSel_e;

  typedef struct packed {
    opaSel_e opaSel;
    logic    opbFromZ;
    logic    parkLoad;
  } dpCtl_t;
endpackage

// File: rtl/vec_add_pipe.sv
module vec_add_pipe #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumZ
);
  logic [WIDTH-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= opA + opB;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stage[i] <= '0;
      else       stage[i] <= stage[i-1];
    end
  end

  assign sumZ = stage[DEPTH-1];
endmodule

// File: rtl/vec_reducer_dp.sv
module vec_reducer_dp
  import vec_reducer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [WIDTH-1:0] inData,
  output logic [WIDTH-1:0] sumZ
);
  logic [WIDTH-1:0] parkReg;
  logic [WIDTH-1:0] opA;
  logic [WIDTH-1:0] opB;

  always_comb begin
    case (ctl.opaSel)
      OPA_STREAM: opA = inData;
      OPA_PARK:   opA = parkReg;
      default:    opA = '0;
    endcase
    opB = ctl.opbFromZ ? sumZ : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             parkReg <= '0;
    else if (ctl.parkLoad) parkReg <= sumZ;
  end

  vec_add_pipe #(.WIDTH(WIDTH), .DEPTH(ADD_DEPTH)) u_add (
    .clk  (clk),
    .rstN (rstN),
    .opA  (opA),
    .opB  (opB),
    .sumZ (sumZ)
  );
endmodule

// File: rtl/vec_reducer_ctrl.sv
module vec_reducer_ctrl
  import vec_reducer_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   inLast,
  output dpCtl_t ctl,
  output logic   inReady,
  output logic   sumDone
);
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign accept  = inValid && !busy;
  assign inReady = !busy;
  assign sumDone = busy && (cnt == CNT_W'(FINAL_CYC));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (accept && inLast) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(1);
      end
    end else if (cnt == CNT_W'(FINAL_CYC)) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    ctl.opaSel   = OPA_ZERO;
    ctl.opbFromZ = 1'b0;
    ctl.parkLoad = 1'b0;
    if (!busy) begin
      // Streaming: recirculate the partial sums, inject zero on empty cycles.
      ctl.opaSel   = accept ? OPA_STREAM : OPA_ZERO;
      ctl.opbFromZ = 1'b1;
    end else begin
      case (int'(cnt))
        PARK_A, PARK_B, PARK_C: ctl.parkLoad = 1'b1;
        MERGE_A, MERGE_B, MERGE_C: begin
          ctl.opaSel   = OPA_PARK;
          ctl.opbFromZ = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vec_reducer.sv
module vec_reducer
  import vec_reducer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  input  logic [WIDTH-1:0] inData,
  output logic             inReady,
  output logic [WIDTH-1:0] sumOut,
  output logic             sumDone
);
  dpCtl_t ctl;

  vec_reducer_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .ctl     (ctl),
    .inReady (inReady),
    .sumDone (sumDone)
  );

  vec_reducer_dp #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .inData (inData),
    .sumZ   (sumOut)
  );
endmodule

// File: rtl/vec_reducer_chk.sv
module vec_reducer_chk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inLast,
  input logic inReady,
  input logic sumDone
);
  logic lastAcc;
  assign lastAcc = inValid && inReady && inLast;

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (inReady && !sumDone)); // R1

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    lastAcc |=> !inReady); // R7

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    sumDone |-> $past(lastAcc, 12)); // R5

  AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (!rstN)
    $past(lastAcc, 12) |-> sumDone); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sumDone |=> !sumDone); // R5

  AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    sumDone |=> inReady); // R9

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    sumDone |-> !inReady); // R7
endmodule

bind vec_reducer vec_reducer_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inLast  (inLast),
  .inReady (inReady),
  .sumDone (sumDone)
);

// File: tb/tb_vec_reducer.sv
module tb_vec_reducer;
  localparam int WIDTH = 32;
  localparam int DONE_AT = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic             inLast = 1'b0;
  logic [WIDTH-1:0] inData = '0;
  logic             inReady;
  logic [WIDTH-1:0] sumOut;
  logic             sumDone;

  int total = 0;
  int failed = 0;

  always #2 clk = ~clk;

  vec_reducer #(.WIDTH(WIDTH)) dut (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .inData  (inData),
    .inReady (inReady),
    .sumOut  (sumOut),
    .sumDone (sumDone)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Streams n elements base, base+step, ...; an empty cycle is placed before index gapAt.
  task automatic runVec(input string req, input int n, input logic [WIDTH-1:0] base,
                        input logic [WIDTH-1:0] step, input int gapAt);
    logic [WIDTH-1:0] expSum = '0;
    for (int i = 0; i < n; i++) begin
      logic [WIDTH-1:0] v = base + step * WIDTH'(i);
      if (i == gapAt) begin
        @(negedge clk);
        inValid = 1'b0; inLast = 1'b1; inData = 32'hDEAD_BEEF;  // R4 junk on an empty cycle
        @(posedge clk);
      end
      @(negedge clk);
      chk(inReady == 1'b1, "R3", {req, " ready while streaming"}, WIDTH'(inReady), 1);
      inValid = 1'b1; inLast = (i == n - 1); inData = v;
      expSum = expSum + v;
      @(posedge clk);
    end
    for (int k = 1; k <= DONE_AT; k++) begin
      @(negedge clk);
      chk(inReady == 1'b0, "R7", {req, " ready low in drain"}, WIDTH'(inReady), 0);
      chk(sumDone == (k == DONE_AT), "R5", {req, " done timing"}, WIDTH'(sumDone),
          WIDTH'(k == DONE_AT));
      if (k == DONE_AT) begin
        chk(sumOut == expSum, req, {req, " sum"}, sumOut, expSum);
        inValid = 1'b0; inLast = 1'b0; inData = '0;
      end else begin
        inValid = 1'b1; inLast = 1'b1; inData = 32'h5A5A_0000 + WIDTH'(k); // R7 ignored
      end
    end
  endtask

  task automatic idleCheck(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      chk(sumDone == 1'b0, "R10", "no done while idle", WIDTH'(sumDone), 0);
      chk(inReady == 1'b1, "R10", "ready while idle", WIDTH'(inReady), 1);
    end
  endtask

  task automatic resetCheck();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b1, "R1", "ready after reset", WIDTH'(inReady), 1);
    chk(sumDone == 1'b0, "R1", "done after reset", WIDTH'(sumDone), 0);
  endtask

  initial begin
    fork
      begin
        resetCheck();
        idleCheck(10);
        runVec("R2", 8, 32'd1, 32'd1, -1);          // 1..8
        runVec("R2", 4, 32'd100, 32'd7, -1);
        runVec("R6", 1, 32'h1234_5678, 32'd0, -1);
        runVec("R6", 2, 32'd9, 32'd11, -1);
        runVec("R6", 3, 32'd1000, 32'd1000, -1);
        runVec("R4", 6, 32'd3, 32'd5, 2);
        runVec("R4", 5, 32'd40, 32'd2, 0);
        runVec("R8", 6, 32'hFFFF_FFF0, 32'd3, -1);
        runVec("R9", 17, 32'h0001_0000, 32'h0000_0101, -1);
        runVec("R9", 2, 32'd5, 32'd5, -1);
        idleCheck(20);
      end
      begin
        #(4 * 100000);
        failed++; total++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule